// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block stores one received frame into a packet page of buffer memory. A frame begins with a one-cycle start pulse that carries its length in bytes. The block checks the receive-control word and the page grant, then decides whether to accept the frame. An accepted frame claims the granted page and is written through a byte-wide port, one byte per cycle at ascending addresses.

The stored image has a fixed layout:

- a little-endian status word;
- a little-endian stored byte count;
- the payload, with short frames zero-padded to the minimum length;
- an optional CRC-32;
- a closing word that holds the final odd byte and a control byte, or zeros for an even-length frame.

When the last byte is written, the page number is pushed to the receive queue and the receive interrupt is raised.

The block takes payload bytes from a valid/ready stream only while it needs them. It generates pad bytes internally. A busy flag covers the whole write.

Top module: `rxbuf_writer`

## Requirements
- R1: A frame is accepted only when control bit 8 (enable) is 1, control bit 15 (soft reset) is 0 and `pg_avail` is 1. Otherwise `pg_take` stays low, nothing is written and `busy` stays low.
- R2: The stored count is the padded length rounded down to even, plus 6, plus 4 when the CRC is kept. A frame whose stored count exceeds 2048 is refused as in R1.
- R3: Address 0 holds the status low byte and address 1 the status high byte. Address 2 holds the count low byte and address 3 the count high byte.
- R4: A frame shorter than 64 bytes is padded with zero bytes to 64 bytes. Only `rx_len` bytes are taken from the stream. Payload byte k goes to address 4+k for every k below the even-rounded padded length.
- R5: Status bit 12 is set when the padded length is odd. Status bit 11 is set when the padded length exceeds 1518. All other status bits are 0.
- R6: The CRC is kept unless control bit 9 is 1. It is computed over all padded bytes, including any odd final byte, using the reflected polynomial 0xEDB88320, an all-ones initial value and a final complement. It is written low byte first, starting right after the even-rounded payload.
- R7: The last two stored bytes are either the odd final byte followed by 0x20, or 0x00 0x00 for an even padded length.
- R8: `pg_take` pulses for one cycle in the accepting cycle. All writes go to the granted page. Consecutive write cycles use consecutive addresses.
- R9: The cycle after the final write, `rxq_push` and `rx_int_set` pulse together for one cycle with the page number on `rxq_page`. `busy` is low in the following cycle.
- R10: `busy` is high from the cycle after acceptance through the push cycle. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_ctrl | input | 16 | Receive-control word (bit 8 enable, bit 9 strip CRC, bit 15 soft reset) |
| rx_start | input | 1 | One-cycle frame start |
| rx_len | input | LEN_W | Frame length in bytes, valid with `rx_start` |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte taken this cycle when valid |
| pg_avail | input | 1 | A free page is granted |
| pg_num | input | PAGE_W | Number of the granted page |
| pg_take | output | 1 | Granted page claimed |
| mem_we | output | 1 | Page memory write strobe |
| mem_page | output | PAGE_W | Page being written |
| mem_addr | output | ADDR_W | Byte address inside the page |
| mem_wdata | output | 8 | Write data |
| rxq_push | output | 1 | Append page to receive queue |
| rxq_page | output | PAGE_W | Page number for the queue |
| rx_int_set | output | 1 | Set receive interrupt |
| busy | output | 1 | Frame write in progress |

## Verification
The assertions assume that the source sends no payload bytes for a refused frame. They also assume that `pg_avail` and `pg_num` describe a real free page in the start cycle, and that `rx_len` is only sampled with `rx_start`.

The stimulus follows these rules. It drives the stream only after seeing a grant, and it presents exactly `rx_len` bytes. It holds the stream idle on refusals. The only start pulse it issues mid-frame is the one deliberately fired while busy. Payload valid is sometimes withheld to stall the writer. Lengths are chosen at the pad, odd and too-long boundaries and on both sides of the page-size limit.

// File: rtl/rxw_pkg.sv
// Package: shared constants, state type and CRC step for the receive buffer writer.
// Assumes byte-serial CRC processing, least significant bit first.
package rxw_pkg;

    localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;
    localparam int          ST_ODD    = 12;
    localparam int          ST_LONG   = 11;
    localparam logic [7:0]  TAIL_ODD  = 8'h20;

    typedef enum logic [2:0] {
        W_IDLE,
        W_HDR,
        W_PAY,
        W_CRC,
        W_TAIL,
        W_DONE
    } wstate_t;

    // Advance a reflected CRC-32 register by one byte.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'b0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxw_plan.sv
// Module: frame admission and layout planner.
// Purely combinational; derives padded length, stored count, status word and
// the accept decision from the start-cycle length and control word.
module rxw_plan #(
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 2048,
    parameter int MIN_FRAME  = 64,
    parameter int MAX_FRAME  = 1518,
    parameter int EN_BIT     = 8,
    parameter int STRIP_BIT  = 9,
    parameter int SRST_BIT   = 15,
    localparam int CNT_W     = LEN_W + 1
) (
    input  logic [15:0]      ctrl,
    input  logic [LEN_W-1:0] len,
    input  logic             pg_avail,
    output logic             accept,
    output logic             keep_crc,
    output logic [LEN_W-1:0] pad_len,
    output logic [LEN_W-1:0] even_len,
    output logic             odd,
    output logic [CNT_W-1:0] count,
    output logic [15:0]      status
);
    import rxw_pkg::*;

    logic fits;
    logic too_long;
    logic ctrl_unused;

    assign ctrl_unused = ^ctrl;

    // Pad short frames and derive the even-rounded length.
    always_comb begin
        pad_len  = (len < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : len;
        even_len = {pad_len[LEN_W-1:1], 1'b0};
        odd      = pad_len[0];
        too_long = pad_len > LEN_W'(MAX_FRAME);
    end

    // Stored byte count and page-size fit.
    always_comb begin
        keep_crc = !ctrl[STRIP_BIT];
        count    = {1'b0, even_len} + CNT_W'(6) + (keep_crc ? CNT_W'(4) : CNT_W'(0));
        fits     = count <= CNT_W'(PAGE_BYTES);
    end

    // Admission decision.
    always_comb begin
        accept = ctrl[EN_BIT] && !ctrl[SRST_BIT] && pg_avail && fits;
    end

    // Status word assembly.
    always_comb begin
        status          = '0;
        status[ST_ODD]  = odd;
        status[ST_LONG] = too_long;
    end

endmodule

// File: rtl/rxw_crc.sv
// Module: byte-serial CRC-32 accumulator.
// Cleared at frame acceptance, advanced once per padded byte; the output is
// the complemented register, ready to store.
module rxw_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] value
);
    import rxw_pkg::*;

    logic [31:0] acc;

    // Accumulate one byte per enabled cycle, reload all ones on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '1;
        end else if (clear) begin
            acc <= '1;
        end else if (en) begin
            acc <= crc_step(acc, data);
        end
    end

    assign value = ~acc;

endmodule

// File: rtl/rxw_seq.sv
// Module: write sequencer.
// Latches the frame plan on acceptance and walks header, payload, CRC and
// closing word, one byte per cycle, then issues the queue push.
// Assumes the source presents bytes only while in_ready is high.
module rxw_seq #(
    parameter int LEN_W  = 12,
    parameter int PAGE_W = 2,
    parameter int ADDR_W = 11,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [PAGE_W-1:0] pg_num,
    input  logic [LEN_W-1:0]  len,
    input  logic [LEN_W-1:0]  pad_len,
    input  logic [LEN_W-1:0]  even_len,
    input  logic              odd,
    input  logic              keep_crc,
    input  logic [CNT_W-1:0]  count,
    input  logic [15:0]       status,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic [31:0]       crc_val,
    output logic              in_ready,
    output logic              mem_we,
    output logic [PAGE_W-1:0] mem_page,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              crc_en,
    output logic [7:0]        crc_byte,
    output logic              push,
    output logic              busy
);
    import rxw_pkg::*;

    wstate_t           state;
    logic [1:0]        sub;
    logic [LEN_W-1:0]  idx;
    logic [ADDR_W-1:0] addr_q;
    logic [PAGE_W-1:0] page_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  pad_q;
    logic [LEN_W-1:0]  even_q;
    logic              odd_q;
    logic              keep_q;
    logic [15:0]       cnt_q;
    logic [15:0]       status_q;
    logic [7:0]        odd_byte;

    logic       from_src;
    logic       step;
    logic       wr_pay;
    logic       last_pay;
    logic [7:0] pay_byte;

    // Payload cycle decode.
    always_comb begin
        from_src = idx < len_q;
        pay_byte = from_src ? in_data : 8'h00;
        step     = !from_src || in_valid;
        wr_pay   = idx < even_q;
        last_pay = idx == (pad_q - LEN_W'(1));
    end

    // State, counters and latched frame plan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= W_IDLE;
            sub      <= '0;
            idx      <= '0;
            addr_q   <= '0;
            page_q   <= '0;
            len_q    <= '0;
            pad_q    <= '0;
            even_q   <= '0;
            odd_q    <= 1'b0;
            keep_q   <= 1'b0;
            cnt_q    <= '0;
            status_q <= '0;
            odd_byte <= '0;
        end else begin
            case (state)
                W_IDLE: begin
                    if (go) begin
                        state    <= W_HDR;
                        sub      <= '0;
                        idx      <= '0;
                        addr_q   <= '0;
                        page_q   <= pg_num;
                        len_q    <= len;
                        pad_q    <= pad_len;
                        even_q   <= even_len;
                        odd_q    <= odd;
                        keep_q   <= keep_crc;
                        cnt_q    <= 16'(count);
                        status_q <= status;
                    end
                end
                W_HDR: begin
                    addr_q <= addr_q + ADDR_W'(1);
                    sub    <= sub + 2'd1;
                    if (sub == 2'd3) begin
                        state <= W_PAY;
                    end
                end
                W_PAY: begin
                    if (step) begin
                        idx <= idx + LEN_W'(1);
                        if (wr_pay) begin
                            addr_q <= addr_q + ADDR_W'(1);
                        end else begin
                            odd_byte <= pay_byte;
                        end
                        if (last_pay) begin
                            state <= keep_q ? W_CRC : W_TAIL;
                            sub   <= '0;
                        end
                    end
                end
                W_CRC: begin
                    addr_q <= addr_q + ADDR_W'(1);
                    sub    <= sub + 2'd1;
                    if (sub == 2'd3) begin
                        state <= W_TAIL;
                        sub   <= '0;
                    end
                end
                W_TAIL: begin
                    addr_q <= addr_q + ADDR_W'(1);
                    sub    <= sub + 2'd1;
                    if (sub == 2'd1) begin
                        state <= W_DONE;
                    end
                end
                W_DONE: begin
                    state <= W_IDLE;
                end
                default: begin
                    state <= W_IDLE;
                end
            endcase
        end
    end

    // Per-state write port, stream handshake and CRC feed.
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = 8'h00;
        in_ready  = 1'b0;
        crc_en    = 1'b0;
        crc_byte  = pay_byte;
        push      = 1'b0;
        case (state)
            W_HDR: begin
                mem_we = 1'b1;
                case (sub)
                    2'd0:    mem_wdata = status_q[7:0];
                    2'd1:    mem_wdata = status_q[15:8];
                    2'd2:    mem_wdata = cnt_q[7:0];
                    default: mem_wdata = cnt_q[15:8];
                endcase
            end
            W_PAY: begin
                in_ready  = from_src;
                crc_en    = step;
                mem_we    = step && wr_pay;
                mem_wdata = pay_byte;
            end
            W_CRC: begin
                mem_we = 1'b1;
                case (sub)
                    2'd0:    mem_wdata = crc_val[7:0];
                    2'd1:    mem_wdata = crc_val[15:8];
                    2'd2:    mem_wdata = crc_val[23:16];
                    default: mem_wdata = crc_val[31:24];
                endcase
            end
            W_TAIL: begin
                mem_we = 1'b1;
                if (sub == 2'd0) begin
                    mem_wdata = odd_q ? odd_byte : 8'h00;
                end else begin
                    mem_wdata = odd_q ? TAIL_ODD : 8'h00;
                end
            end
            W_DONE: begin
                push = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign mem_addr = addr_q;
    assign mem_page = page_q;
    assign busy     = state != W_IDLE;

endmodule

// File: rtl/rxbuf_writer.sv
// Module: receive frame buffer writer (top).
// Admits a frame on rx_start, claims the granted page, writes the stored
// image byte by byte and pushes the page to the receive queue.
// Assumes pg_avail/pg_num are valid in the start cycle and that no payload
// bytes are offered for a refused frame.
module rxbuf_writer #(
    parameter int  LEN_W      = 12,
    parameter int  PAGE_W     = 2,
    parameter int  PAGE_BYTES = 2048,
    parameter int  MIN_FRAME  = 64,
    parameter int  MAX_FRAME  = 1518,
    parameter int  EN_BIT     = 8,
    parameter int  STRIP_BIT  = 9,
    parameter int  SRST_BIT   = 15,
    localparam int ADDR_W     = $clog2(PAGE_BYTES),
    localparam int CNT_W      = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       rx_ctrl,
    input  logic              rx_start,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    input  logic              pg_avail,
    input  logic [PAGE_W-1:0] pg_num,
    output logic              pg_take,
    output logic              mem_we,
    output logic [PAGE_W-1:0] mem_page,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              rxq_push,
    output logic [PAGE_W-1:0] rxq_page,
    output logic              rx_int_set,
    output logic              busy
);

    logic             accept;
    logic             keep_crc;
    logic [LEN_W-1:0] pad_len;
    logic [LEN_W-1:0] even_len;
    logic             odd;
    logic [CNT_W-1:0] count;
    logic [15:0]      status;
    logic             go;
    logic             crc_en;
    logic [7:0]       crc_byte;
    logic [31:0]      crc_val;
    logic             push;

    rxw_plan #(
        .LEN_W     (LEN_W),
        .PAGE_BYTES(PAGE_BYTES),
        .MIN_FRAME (MIN_FRAME),
        .MAX_FRAME (MAX_FRAME),
        .EN_BIT    (EN_BIT),
        .STRIP_BIT (STRIP_BIT),
        .SRST_BIT  (SRST_BIT)
    ) u_plan (
        .ctrl    (rx_ctrl),
        .len     (rx_len),
        .pg_avail(pg_avail),
        .accept  (accept),
        .keep_crc(keep_crc),
        .pad_len (pad_len),
        .even_len(even_len),
        .odd     (odd),
        .count   (count),
        .status  (status)
    );

    // A start is taken only while idle and admitted.
    assign go      = rx_start && !busy && accept;
    assign pg_take = go;

    rxw_crc u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(go),
        .en   (crc_en),
        .data (crc_byte),
        .value(crc_val)
    );

    rxw_seq #(
        .LEN_W (LEN_W),
        .PAGE_W(PAGE_W),
        .ADDR_W(ADDR_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .pg_num   (pg_num),
        .len      (rx_len),
        .pad_len  (pad_len),
        .even_len (even_len),
        .odd      (odd),
        .keep_crc (keep_crc),
        .count    (count),
        .status   (status),
        .in_valid (in_valid),
        .in_data  (in_data),
        .crc_val  (crc_val),
        .in_ready (in_ready),
        .mem_we   (mem_we),
        .mem_page (mem_page),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .crc_en   (crc_en),
        .crc_byte (crc_byte),
        .push     (push),
        .busy     (busy)
    );

    assign rxq_push   = push;
    assign rx_int_set = push;
    assign rxq_page   = mem_page;

endmodule

// File: rtl/rxbuf_writer_sva.sv
// Module: protocol checker for rxbuf_writer, attached by bind.
// Assumes inputs follow the start/grant/stream rules in the brief.
module rxbuf_writer_sva #(
    parameter int PAGE_W   = 2,
    parameter int ADDR_W   = 11,
    parameter int EN_BIT   = 8,
    parameter int SRST_BIT = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       rx_ctrl,
    input logic              pg_avail,
    input logic              pg_take,
    input logic              in_ready,
    input logic              mem_we,
    input logic [PAGE_W-1:0] mem_page,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rxq_push,
    input logic              rx_int_set,
    input logic              busy
);

    assert_take_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pg_take |-> (rx_ctrl[EN_BIT] && !rx_ctrl[SRST_BIT] && pg_avail && !busy));

    assert_take_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pg_take |=> !pg_take);

    assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_page_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_page));

    assert_push_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_push |-> rx_int_set);

    assert_push_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_push |=> !busy);

    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pg_take |=> busy);

    assert_write_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || in_ready) |-> busy);

endmodule

bind rxbuf_writer rxbuf_writer_sva #(
    .PAGE_W  (PAGE_W),
    .ADDR_W  (ADDR_W),
    .EN_BIT  (EN_BIT),
    .SRST_BIT(SRST_BIT)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_ctrl   (rx_ctrl),
    .pg_avail  (pg_avail),
    .pg_take   (pg_take),
    .in_ready  (in_ready),
    .mem_we    (mem_we),
    .mem_page  (mem_page),
    .mem_addr  (mem_addr),
    .rxq_push  (rxq_push),
    .rx_int_set(rx_int_set),
    .busy      (busy)
);

// File: tb/tb_rxbuf_writer.sv
// Bench: behavioural model of the stored image, compared at every negedge.
module tb_rxbuf_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rx_ctrl = '0;
    logic        rx_start = 1'b0;
    logic [11:0] rx_len = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        pg_avail = 1'b0;
    logic [1:0]  pg_num = '0;
    logic        pg_take;
    logic        mem_we;
    logic [1:0]  mem_page;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        rxq_push;
    logic [1:0]  rxq_page;
    logic        rx_int_set;
    logic        busy;

    int total = 0;
    int bad = 0;
    bit mon_on = 1'b0;
    int exp_w[$];
    string exp_t[$];
    int exp_p[$];

    always #2 clk = ~clk;

    rxbuf_writer dut (
        .clk(clk), .rst_n(rst_n), .rx_ctrl(rx_ctrl), .rx_start(rx_start),
        .rx_len(rx_len), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .pg_avail(pg_avail), .pg_num(pg_num),
        .pg_take(pg_take), .mem_we(mem_we), .mem_page(mem_page),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rxq_push(rxq_push),
        .rxq_page(rxq_page), .rx_int_set(rx_int_set), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] src_byte(input int k, input int seed);
        return 8'((k * 13 + seed * 29 + 7) & 8'hff);
    endfunction

    function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (b[i]) begin
            c = c ^ {24'b0, b[i]};
            for (int j = 0; j < 8; j++) begin
                if (c[0]) c = (c >> 1) ^ 32'hEDB8_8320;
                else      c = c >> 1;
            end
        end
        return ~c;
    endfunction

    function automatic void exp_byte(input int page, input int addr, input logic [7:0] d, input string t);
        exp_w.push_back((page << 24) | (addr << 8) | int'(d));
        exp_t.push_back(t);
    endfunction

    // Monitor: compare every write and push against the model queues.
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (mem_we) begin
                int a;
                a = (int'(mem_page) << 24) | (int'(mem_addr) << 8) | int'(mem_wdata);
                if (exp_w.size() == 0) begin
                    chk(1'b0, "R1 unexpected write", a, 0);
                end else begin
                    int e;
                    string t;
                    e = exp_w.pop_front();
                    t = exp_t.pop_front();
                    chk(a == e, t, a, e);
                end
            end
            if (rxq_push) begin
                if (exp_p.size() == 0) begin
                    chk(1'b0, "R9 unexpected push", int'(rxq_page), 0);
                end else begin
                    int p;
                    p = exp_p.pop_front();
                    chk(int'(rxq_page) == p && exp_w.size() == 0, "R9 push page/order", int'(rxq_page), p);
                    chk(rx_int_set == 1'b1, "R9 interrupt with push", int'(rx_int_set), 1);
                end
            end
        end
    end

    task automatic run_frame(input int len, input logic [15:0] ctrl, input bit avail,
                             input int page, input bit gappy, input int seed, input string req);
        bit en, keep, odd, acc;
        int pad, even, cnt, status, k, cyc;
        logic [7:0] pb[$];
        logic [31:0] c;
        en   = ctrl[8] && !ctrl[15] && avail;
        keep = !ctrl[9];
        pad  = (len < 64) ? 64 : len;
        even = pad & ~1;
        odd  = pad[0];
        cnt  = even + 6 + (keep ? 4 : 0);
        acc  = en && (cnt <= 2048);
        status = (odd ? 32'h1000 : 0) | ((pad > 1518) ? 32'h0800 : 0);
        if (acc) begin
            for (int i = 0; i < pad; i++) pb.push_back(i < len ? src_byte(i, seed) : 8'h00);
            exp_byte(page, 0, 8'(status), "R3 R5 status low");
            exp_byte(page, 1, 8'(status >> 8), "R3 R5 status high");
            exp_byte(page, 2, 8'(cnt), "R2 R3 count low");
            exp_byte(page, 3, 8'(cnt >> 8), "R2 R3 count high");
            for (int i = 0; i < even; i++) exp_byte(page, 4 + i, pb[i], "R4 payload");
            if (keep) begin
                c = ref_crc(pb);
                for (int i = 0; i < 4; i++) exp_byte(page, 4 + even + i, 8'(c >> (8 * i)), "R6 crc");
            end
            exp_byte(page, cnt - 2, odd ? pb[pad - 1] : 8'h00, "R7 final byte");
            exp_byte(page, cnt - 1, odd ? 8'h20 : 8'h00, "R7 control byte");
            exp_p.push_back(page);
        end
        @(posedge clk); #1;
        rx_ctrl = ctrl; pg_avail = avail; pg_num = 2'(page);
        rx_start = 1'b1; rx_len = 12'(len);
        @(negedge clk);
        chk(pg_take == acc, req, int'(pg_take), int'(acc));
        @(posedge clk); #1;
        rx_start = 1'b0;
        chk(busy == acc, {req, " R10 busy after start"}, int'(busy), int'(acc));
        if (acc) begin
            k = 0;
            cyc = 0;
            while (k < len) begin
                in_valid = gappy ? ((cyc % 3) != 1) : 1'b1;
                in_data  = src_byte(k, seed);
                if (in_valid && in_ready) k++;
                cyc++;
                @(posedge clk); #1;
            end
            in_valid = 1'b0;
            while (busy) begin
                @(posedge clk); #1;
            end
            chk(exp_w.size() == 0 && exp_p.size() == 0, {req, " R9 image complete"}, exp_w.size(), 0);
        end else begin
            repeat (3) begin
                @(posedge clk); #1;
                chk(busy == 1'b0, {req, " refused stays idle"}, int'(busy), 0);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Stimulus.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0 && mem_we == 1'b0 && in_ready == 1'b0, "R10 reset idle", int'(busy), 0);
        chk(rxq_push == 1'b0 && pg_take == 1'b0, "R9 reset quiet", int'(rxq_push), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        mon_on = 1'b1;

        run_frame(60,   16'h0100, 1'b1, 1, 1'b0, 1, "R4 short frame padded");
        run_frame(64,   16'h0100, 1'b1, 2, 1'b0, 2, "R6 minimum frame");
        run_frame(65,   16'h0100, 1'b1, 3, 1'b0, 3, "R7 odd frame");
        run_frame(65,   16'h0300, 1'b1, 0, 1'b1, 4, "R6 stripped crc stalled");
        run_frame(1519, 16'h0100, 1'b1, 1, 1'b0, 5, "R5 too long");
        run_frame(2042, 16'h0300, 1'b1, 2, 1'b0, 6, "R2 fits exactly stripped");
        run_frame(2039, 16'h0100, 1'b1, 3, 1'b1, 7, "R2 fits exactly odd");
        run_frame(2040, 16'h0100, 1'b1, 0, 1'b0, 8, "R2 over page");
        run_frame(2044, 16'h0300, 1'b1, 0, 1'b0, 9, "R2 over page stripped");
        run_frame(100,  16'h0000, 1'b1, 0, 1'b0, 10, "R1 disabled");
        run_frame(100,  16'h8100, 1'b1, 0, 1'b0, 11, "R1 soft reset");
        run_frame(100,  16'h0100, 1'b0, 0, 1'b0, 12, "R1 no page");

        fork
            run_frame(100, 16'h0100, 1'b1, 2, 1'b0, 13, "R8 frame under restart");
            begin
                repeat (8) @(posedge clk);
                #1;
                rx_start = 1'b1;
                rx_len = 12'd70;
                @(negedge clk);
                chk(pg_take == 1'b0, "R10 start while busy ignored", int'(pg_take), 0);
                @(posedge clk); #1;
                rx_start = 1'b0;
            end
        join
        run_frame(70, 16'h0100, 1'b1, 1, 1'b0, 14, "R8 next frame after restart");

        repeat (4) @(posedge clk);
        chk(exp_w.size() == 0 && exp_p.size() == 0, "R9 nothing outstanding", exp_w.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule